// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor

This block watches a T1 serial PCM stream that is already on system-side timing. It receives one data bit per clock, together with a frame sync pulse and a multiframe sync pulse. Inside each 193-bit frame it tracks the bit position, the channel and the frame number. In the signaling frames it captures the least significant bit of every channel into a per-channel buffer that holds four bits. Which frames carry signaling depends on the framing select. With 12-frame superframing, A and B are captured. With 24-frame extended superframing, A, B, C and D are captured. In the 12-frame case the C and D fields repeat the A and B values of the multiframe before.

The data bit itself passes through untouched, one clock late, so clear-channel payload is never altered. A strobe aligned with the delayed data marks each channel's LSB bit time, which lets downstream logic re-insert signaling where it chooses. When a multiframe ends, the captured buffer is copied into a registered 96-bit result and a one-cycle completion pulse is raised. A separate output stage (integration, freeze) consumes that result.

Top module: `rbs_extract`

## Requirements
- R1: `ser_out` equals the `ser_in` value of the previous clock, unaltered, in every framing mode and for every bit position.
- R2: `lsb_strobe` is high in exactly the cycle after an input bit at frame position 8k (k = 1..24, where position 0 is the framing bit), and low after every other position.
- R3: A cycle with `fsync` or `msync` high is position 0 of a frame. `msync` makes that frame number 1. `fsync` alone, or a free-running wrap after position 192, advances the frame number, and the frame number returns to 1 after frame 12 (`esf_mode`=0) or frame 24 (`esf_mode`=1).
- R4: With `esf_mode`=1, channel c (0..23) is the LSB at position 8(c+1). `mf_sig[4c+0]` holds the bit from frame 6, `[4c+1]` from frame 12, `[4c+2]` from frame 18 and `[4c+3]` from frame 24.
- R5: With `esf_mode`=0, `mf_sig[4c+0]` holds channel c's LSB from frame 6 and `[4c+1]` holds it from frame 12.
- R6: With `esf_mode`=0, `mf_sig[4c+2]` and `[4c+3]` hold the `[4c+0]` and `[4c+1]` values of the previously completed multiframe, whatever its mode (zero if there was none since reset).
- R7: `mf_done` is a one-cycle pulse that comes two clocks after the input cycle carrying position 192 of the last frame (12 or 24). The new `mf_sig` appears in that same cycle.
- R8: `mf_sig` changes only in a cycle with `mf_done` high. Non-LSB bits, and LSBs in frames that are not multiples of 6, have no effect on it.
- R9: While `rst` is high, `ser_out`, `lsb_strobe` and `mf_done` are 0 and `mf_sig` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one PCM bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial PCM data bit |
| fsync | input | 1 | Marks the framing bit of a frame |
| msync | input | 1 | Marks the framing bit of frame 1 of a multiframe |
| esf_mode | input | 1 | 0: 12-frame superframe, 1: 24-frame extended superframe |
| ser_out | output | 1 | PCM data delayed one clock, unmodified |
| lsb_strobe | output | 1 | High while `ser_out` carries a channel LSB |
| mf_done | output | 1 | One-cycle pulse when a multiframe completes |
| mf_sig | output | 96 | Signaling of the last multiframe, 4 bits per channel (A,B,C,D from bit 0) |

## Verification
`ser_out` and `lsb_strobe` are due one clock after the bit that causes them. `mf_done`, together with the refreshed `mf_sig`, is due two clocks after the last frame's final LSB. The bench drives each bit on a falling edge, and on the next falling edge it compares the outputs against values carried forward from the previous drive. It uses a two-stage delay of its own for the completion pulse. Between pulses, every falling edge confirms that `mf_sig` has not moved, even while noise is applied on non-signaling positions.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  parameter int DEF_CHANNELS   = 24;
  parameter int DEF_BITS_PER_CH = 8;
  parameter int DEF_SF_FRAMES  = 12;
  parameter int DEF_ESF_FRAMES = 24;
  parameter int DEF_SIG_STEP   = 6;

  typedef enum logic {
    FRAMING_SF  = 1'b0,
    FRAMING_ESF = 1'b1
  } framing_e;
endpackage

// File: rtl/rbs_timing.sv
module rbs_timing
  import rbs_pkg::*;
#(
  parameter int CHANNELS    = DEF_CHANNELS,
  parameter int BITS_PER_CH = DEF_BITS_PER_CH,
  parameter int SF_FRAMES   = DEF_SF_FRAMES,
  parameter int ESF_FRAMES  = DEF_ESF_FRAMES,
  parameter int SIG_STEP    = DEF_SIG_STEP,
  localparam int CH_W       = $clog2(CHANNELS),
  localparam int SLOT_W     = $clog2(ESF_FRAMES / SIG_STEP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              msync,
  input  logic              esf,
  output logic              lsb,
  output logic              sig_we,
  output logic [SLOT_W-1:0] slot,
  output logic [CH_W-1:0]   chan,
  output logic              last
);
  localparam int FRAME_BITS = CHANNELS * BITS_PER_CH + 1;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int FRM_W      = $clog2(ESF_FRAMES + 1);
  localparam int BIT_W      = $clog2(BITS_PER_CH);

  framing_e         mode;
  logic [POS_W-1:0] pos_q, cur_pos, pos_m1;
  logic [FRM_W-1:0] frame_q, cur_frame, n_frames;
  logic             wrap, restart, advance, sig_frame;

  assign mode = framing_e'(esf);

  always_comb begin
    n_frames  = (mode == FRAMING_ESF) ? FRM_W'(ESF_FRAMES) : FRM_W'(SF_FRAMES);
    wrap      = (pos_q == POS_W'(FRAME_BITS - 1));
    restart   = fsync | msync | wrap;
    advance   = restart & ~msync;
    cur_pos   = restart ? '0 : pos_q + 1'b1;
    if (msync)
      cur_frame = FRM_W'(1);
    else if (advance)
      cur_frame = (frame_q >= n_frames) ? FRM_W'(1) : frame_q + 1'b1;
    else
      cur_frame = frame_q;
    pos_m1    = cur_pos - 1'b1;
    lsb       = (cur_pos != '0) && (cur_pos[BIT_W-1:0] == '0);
    chan      = CH_W'(pos_m1 >> BIT_W);
    sig_frame = ((32'(cur_frame) % SIG_STEP) == 0);
    slot      = SLOT_W'(32'(cur_frame) / SIG_STEP - 1);
    sig_we    = lsb & sig_frame;
    last      = lsb && (cur_pos == POS_W'(FRAME_BITS - 1)) && (cur_frame == n_frames);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= POS_W'(FRAME_BITS - 1);
      frame_q <= FRM_W'(ESF_FRAMES);
    end else begin
      pos_q   <= cur_pos;
      frame_q <= cur_frame;
    end
  end

  // R3: any sync makes the following position the first channel bit
  p_fsync_r3: assert property (@(posedge clk) disable iff (rst)
    (fsync | msync) |=> (pos_q == '0));
  p_msync_r3: assert property (@(posedge clk) disable iff (rst)
    msync |=> (frame_q == FRM_W'(1)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ((pos_q == POS_W'(FRAME_BITS - 1)) && !fsync && !msync) |=> (pos_q == '0));
endmodule

// File: rtl/rbs_capture.sv
module rbs_capture #(
  parameter int CHANNELS = 24,
  parameter int SIG_BITS = 4,
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int SLOT_W  = $clog2(SIG_BITS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         esf,
  input  logic                         we,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [CH_W-1:0]              chan,
  input  logic                         din,
  input  logic                         last,
  output logic                         mf_done,
  output logic [CHANNELS*SIG_BITS-1:0] mf_sig
);
  localparam int PAIR = SIG_BITS / 2;

  logic [SIG_BITS-1:0] cap_mem [CHANNELS];
  logic                last_q;

  // capture store: one writer per cycle, indexed by channel
  always_ff @(posedge clk) begin
    if (we) begin
      cap_mem[chan][slot] <= din;
      if (!esf)
        cap_mem[chan][slot + SLOT_W'(PAIR)] <= mf_sig[32'(chan) * SIG_BITS + 32'(slot)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= 1'b0;
      mf_done <= 1'b0;
      mf_sig  <= '0;
    end else begin
      last_q  <= last;
      mf_done <= last_q;
      if (last_q)
        for (int c = 0; c < CHANNELS; c++)
          mf_sig[c*SIG_BITS +: SIG_BITS] <= cap_mem[c];
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mf_done |=> !mf_done);
  p_done_lat_r7: assert property (@(posedge clk) disable iff (rst)
    last |=> ##1 mf_done);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!mf_done && !$past(rst)) |-> $stable(mf_sig));
endmodule

// File: rtl/rbs_extract.sv
module rbs_extract
  import rbs_pkg::*;
#(
  parameter int CHANNELS    = DEF_CHANNELS,
  parameter int BITS_PER_CH = DEF_BITS_PER_CH,
  parameter int SF_FRAMES   = DEF_SF_FRAMES,
  parameter int ESF_FRAMES  = DEF_ESF_FRAMES,
  parameter int SIG_STEP    = DEF_SIG_STEP,
  localparam int SIG_BITS   = ESF_FRAMES / SIG_STEP
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ser_in,
  input  logic                         fsync,
  input  logic                         msync,
  input  logic                         esf_mode,
  output logic                         ser_out,
  output logic                         lsb_strobe,
  output logic                         mf_done,
  output logic [CHANNELS*SIG_BITS-1:0] mf_sig
);
  localparam int CH_W   = $clog2(CHANNELS);
  localparam int SLOT_W = $clog2(SIG_BITS);

  logic              lsb, sig_we, last;
  logic [SLOT_W-1:0] slot;
  logic [CH_W-1:0]   chan;

  rbs_timing #(
    .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH), .SF_FRAMES(SF_FRAMES),
    .ESF_FRAMES(ESF_FRAMES), .SIG_STEP(SIG_STEP)
  ) i_timing (
    .clk(clk), .rst(rst), .fsync(fsync), .msync(msync), .esf(esf_mode),
    .lsb(lsb), .sig_we(sig_we), .slot(slot), .chan(chan), .last(last)
  );

  rbs_capture #(.CHANNELS(CHANNELS), .SIG_BITS(SIG_BITS)) i_capture (
    .clk(clk), .rst(rst), .esf(esf_mode), .we(sig_we), .slot(slot),
    .chan(chan), .din(ser_in), .last(last), .mf_done(mf_done), .mf_sig(mf_sig)
  );

  // clear-channel path and strobe, both one register deep
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out    <= 1'b0;
      lsb_strobe <= 1'b0;
    end else begin
      ser_out    <= ser_in;
      lsb_strobe <= lsb;
    end
  end

  p_pass_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ser_out == $past(ser_in)));
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
    lsb_strobe |=> !lsb_strobe);
  p_fbit_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fsync | msync)) |-> !lsb_strobe);
endmodule

// File: tb/test_rbs_extract.sv
module test_rbs_extract;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 24;
  localparam int SB  = 4;

  logic clk = 1'b0, rst = 1'b1, ser_in = 1'b0, fsync = 1'b0, msync = 1'b0, esf_mode = 1'b1;
  logic ser_out, lsb_strobe, mf_done;
  logic [NCH*SB-1:0] mf_sig;

  int vectors = 0, errors = 0;
  int m_pos = 192, m_frame = 24;
  logic prev_in = 1'b0, prev_lsb = 1'b0, last1 = 1'b0, last2 = 1'b0, exp_mode_q = 1'b0;
  logic [SB-1:0] exp_cur [NCH];
  logic [SB-1:0] exp_q [NCH];
  logic [1:0]    prev_ab [NCH];
  logic [NCH*SB-1:0] last_sig = '0;

  rbs_extract i_rbs_extract (
    .clk(clk), .rst(rst), .ser_in(ser_in), .fsync(fsync), .msync(msync),
    .esf_mode(esf_mode), .ser_out(ser_out), .lsb_strobe(lsb_strobe),
    .mf_done(mf_done), .mf_sig(mf_sig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic sv(int seed, int c, int s);
    int h = seed * 29 + c * 13 + s * 7 + c * s;
    return h[2] ^ h[0];
  endfunction

  function automatic logic nz(int seed, int f, int p);
    int h = seed * 11 + f * 5 + p * 3 + (p >> 2);
    return h[1] ^ h[3];
  endfunction

  task automatic check1(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // samples the outputs of the previous drive, then drives one new bit
  task automatic drive_bit(logic esf, logic b, logic fs, logic ms);
    int nf, np, nfr;
    logic restart;
    @(negedge clk);
    check1("R1 ser_out", ser_out, prev_in);
    check1("R2 lsb_strobe", lsb_strobe, prev_lsb);
    check1("R7 mf_done (frame count R3)", mf_done, last2);
    if (last2) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < SB; k++)
          check1(exp_mode_q ? "R4 field" : (k < 2 ? "R5 field" : "R6 field"),
                 mf_sig[c*SB+k], exp_q[c][k]);
      last_sig = mf_sig;
    end else begin
      vectors++;
      if (mf_sig !== last_sig) begin
        errors++;
        $display("FAIL R8 mf_sig moved: actual %h expected %h", mf_sig, last_sig);
      end
    end
    last2 = last1;
    rst = 1'b0; esf_mode = esf; ser_in = b; fsync = fs; msync = ms;
    nf = esf ? 24 : 12;
    restart = fs || ms || (m_pos == 192);
    np = restart ? 0 : m_pos + 1;
    if (ms) nfr = 1;
    else if (restart) nfr = (m_frame >= nf) ? 1 : m_frame + 1;
    else nfr = m_frame;
    m_pos = np; m_frame = nfr;
    prev_in = b;
    prev_lsb = (np != 0) && (np % 8 == 0);
    last1 = prev_lsb && (np == 192) && (nfr == nf);
    if (last1) begin
      exp_q = exp_cur;
      exp_mode_q = esf;
    end
  endtask

  task automatic send_mf(logic esf, int seed, logic use_ms, logic use_fs);
    int nf = esf ? 24 : 12;
    logic b;
    for (int c = 0; c < NCH; c++) begin
      exp_cur[c][0] = sv(seed, c, 0);
      exp_cur[c][1] = sv(seed, c, 1);
      exp_cur[c][2] = esf ? sv(seed, c, 2) : prev_ab[c][0];
      exp_cur[c][3] = esf ? sv(seed, c, 3) : prev_ab[c][1];
    end
    for (int f = 1; f <= nf; f++) begin
      drive_bit(esf, nz(seed, f, 0), use_fs, use_ms && (f == 1));
      for (int p = 1; p <= 192; p++) begin
        if ((p % 8 == 0) && (f % 6 == 0)) b = exp_cur[(p-1)/8][f/6-1];
        else b = nz(seed, f, p);
        drive_bit(esf, b, 1'b0, 1'b0);
      end
    end
    for (int c = 0; c < NCH; c++) prev_ab[c] = exp_cur[c][1:0];
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    check1("R9 ser_out reset", ser_out, 1'b0);
    check1("R9 lsb_strobe reset", lsb_strobe, 1'b0);
    check1("R9 mf_done reset", mf_done, 1'b0);
    check1("R9 mf_sig reset", mf_sig == '0, 1'b1);
  endtask

  // mid-frame disturbance, a short frame, then a fresh multiframe
  task automatic test_realign(int seed);
    for (int i = 0; i < 37; i++) drive_bit(1'b0, nz(seed, 3, i), i == 10, 1'b0);
    send_mf(1'b1, seed, 1'b1, 1'b1);
  endtask

  task automatic test_tail;
    repeat (3) drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) prev_ab[c] = 2'b00;
    test_reset();
    send_mf(1'b1, 1, 1'b1, 1'b1);   // R4 with syncs
    send_mf(1'b1, 2, 1'b0, 1'b0);   // R3 free-running
    send_mf(1'b0, 3, 1'b1, 1'b1);   // R5, R6 after extended mode
    send_mf(1'b0, 4, 1'b1, 1'b0);   // R6 from superframe
    test_realign(5);
    send_mf(1'b1, 6, 1'b1, 1'b0);
    test_tail();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule